// File: doc/BRIEF.md
# LIN Slave Response Transmitter

This block drives the response section of a LIN frame (the data bytes and the trailing checksum) from a small local byte buffer. It runs once a valid header has been seen on the bus. A header strobe arms the block. Software then raises a transmit request. When both are present, the block shifts out the selected number of buffer slots on the transmit line. Each byte uses a fixed number of clock cycles per bit, and bytes follow one another with no idle gap.

The bus is read back while the block drives it. Each bit is sampled in the middle of its period and compared with the level being driven. If the two differ, the response is abandoned and a bit-error flag is raised. When a byte completes its stop bit, the value actually seen on the bus is written back into the slot it came from. After a full response, the buffer therefore shows what the bus carried, and this includes the checksum slot. A finished response consumes the header. Another response needs a fresh header strobe.

Top module: `lin_resp_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_done`, `bit_err` and `req_pending` are 0, and all nine buffer slots read 0x00.
- R2: A response starts only when the request bit (`req_pending`) and a header strobe received since the last start are both present. A request alone or a header alone never starts one. The start bit appears on `txd` on the second rising edge after the later of the two strobes.
- R3: Each byte is sent as 10 bit periods of `BIT_CLKS` cycles each: a 0 start bit, then data bits 0 through 7 (LSB first), then a 1 stop bit. Bytes go out back to back from slot 0 upward. `buf_len` counts every slot sent, checksum included, so a value of 9 sends slots 0 to 8.
- R4: At the end of each stop bit, the byte sampled from `rxd` is written into the slot just sent. Host writes through `host_we` are ignored while a response is in progress and are accepted when idle, including on the edge at which a response starts. Slot `i` reads on `buf_q[8*i+7:8*i]`.
- R5: `tx_done` is high for exactly one cycle. It goes high on the edge that ends the stop bit of the last slot, `buf_len*10*BIT_CLKS` cycles after the start bit begins. `req_pending` is 0 from that same edge.
- R6: Once a response completes, a new request does not start transmission until another header strobe arrives.
- R7: If `rxd` differs from the driven level at the mid-bit sample, `bit_err` is set and `txd` returns to 1 on the next edge. `req_pending` clears, `tx_done` does not pulse, and the slot being sent is not rewritten.
- R8: A request with `buf_len` equal to 0 or greater than 9 sends nothing and clears `req_pending` the cycle after it is seen. The pending header stays armed for a later valid request.
- R9: `bit_err` holds its value until the next response starts, and that start clears it.
- R10: `txd` is 1 whenever no response is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_ok | input | 1 | One-cycle strobe: a valid header was received |
| req_set | input | 1 | One-cycle strobe: software sets the transmit request |
| buf_len | input | 4 | Number of slots to send, checksum included (1 to 9 valid) |
| host_we | input | 1 | Host buffer write enable |
| host_idx | input | 4 | Host buffer write slot (0 to 8) |
| host_data | input | 8 | Host buffer write data |
| rxd | input | 1 | Bus receive line, used for readback |
| txd | output | 1 | Bus transmit line |
| tx_done | output | 1 | One-cycle pulse when the response completes |
| bit_err | output | 1 | Readback mismatch flag |
| req_pending | output | 1 | Current state of the transmit request bit |
| buf_q | output | 72 | All nine buffer slots, slot i at bits 8*i+7:8*i |

## Verification
The host buffer write port and the start of a response can act in the same clock edge. At that edge the block is still idle, so the write must land, and its byte must be the one that goes out. The bench provokes this by issuing a request and then writing slot 0 with a new value on the very next cycle, which is the edge where transmission begins. It then decodes slot 0 from the line and compares it with the new value. The opposite case, a write one bit period into the response, must leave both the line and the buffer unchanged. The header strobe and the request strobe are also issued in the same cycle, and the start must still follow.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    localparam int SLOTS      = 9;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = $clog2(SLOTS + 1);
    localparam int LEN_W      = 4;
    localparam int FRAME_BITS = BYTE_W + 2;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int SEL_W      = $clog2(BYTE_W);

    localparam logic [POS_W-1:0] POS_START = '0;
    localparam logic [POS_W-1:0] POS_STOP  = POS_W'(FRAME_BITS - 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {ST_IDLE, ST_SEND} st_e;

    // Position inside the response: which slot, which bit of its frame
    typedef struct packed {
        idx_t             slot;
        logic [POS_W-1:0] pos;
    } cursor_t;

    // One write request into the buffer
    typedef struct packed {
        logic  en;
        idx_t  idx;
        byte_t data;
    } wr_t;

    function automatic logic len_ok(input logic [LEN_W-1:0] n);
        return (n != '0) && (n <= LEN_W'(SLOTS));
    endfunction

    // Level driven on the line for a given frame position of byte b
    function automatic logic line_level(input logic [POS_W-1:0] pos, input byte_t b);
        logic [POS_W-1:0] k;
        k = pos - 1'b1;
        if (pos == POS_START) return 1'b0;
        if (pos == POS_STOP)  return 1'b1;
        return b[k[SEL_W-1:0]];
    endfunction

endpackage

// File: rtl/lin_resp_bitclk.sv
module lin_resp_bitclk #(
    parameter int BIT_CLKS = 16   // must be at least 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mid,
    output logic last
);
    localparam int CW = $clog2(BIT_CLKS);
    localparam logic [CW-1:0] MID_V  = CW'(BIT_CLKS / 2);
    localparam logic [CW-1:0] LAST_V = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    assign mid  = run && (cnt == MID_V);
    assign last = run && (cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R3
    bit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

endmodule

// File: rtl/lin_resp_store.sv
module lin_resp_store
    import lin_resp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_t                      host_wr,
    input  wr_t                      rb_wr,
    input  idx_t                     rd_idx,
    output byte_t                    rd_data,
    output logic [SLOTS*BYTE_W-1:0]  flat
);
    byte_t mem [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (rb_wr.en && rb_wr.idx == idx_t'(g))
                mem[g] <= rb_wr.data;
            else if (host_wr.en && host_wr.idx == idx_t'(g))
                mem[g] <= host_wr.data;
        end
        assign flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++)
            if (rd_idx == idx_t'(i)) rd_data = mem[i];
    end

endmodule

// File: rtl/lin_resp_ctrl.sv
module lin_resp_ctrl
    import lin_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_ok,
    input  logic             req_set,
    input  logic [LEN_W-1:0] buf_len,
    input  logic             rxd,
    input  logic             mid,
    input  logic             last,
    input  byte_t            rd_data,
    output logic             busy,
    output idx_t             rd_idx,
    output wr_t              rb_wr,
    output logic             tx_line,
    output logic             done,
    output logic             bit_err,
    output logic             req_q
);
    st_e              st;
    logic             armed;
    cursor_t          cur;
    logic [LEN_W-1:0] len_l;
    byte_t            shreg;
    logic             go, reject, bit_now, miss, at_stop, last_slot, finish;
    logic [POS_W-1:0] dpos;

    assign busy      = (st == ST_SEND);
    assign go        = req_q && armed && !busy && len_ok(buf_len);
    assign reject    = req_q && armed && !busy && !len_ok(buf_len);
    assign bit_now   = line_level(cur.pos, rd_data);
    assign tx_line   = busy ? bit_now : 1'b1;
    assign miss      = busy && mid && (rxd != bit_now);
    assign at_stop   = (cur.pos == POS_STOP);
    assign last_slot = (cur.slot == idx_t'(len_l - 1'b1));
    assign finish    = busy && last && at_stop && last_slot;
    assign dpos      = cur.pos - 1'b1;
    assign rd_idx    = cur.slot;

    always_comb begin
        rb_wr.en   = busy && last && at_stop;
        rb_wr.idx  = cur.slot;
        rb_wr.data = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            armed   <= 1'b0;
            cur     <= '0;
            len_l   <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            bit_err <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            done <= finish;

            if (go)          armed <= 1'b0;
            else if (hdr_ok) armed <= 1'b1;

            if (reject || finish || miss) req_q <= 1'b0;
            if (req_set && !busy)         req_q <= 1'b1;

            if (go) begin
                st      <= ST_SEND;
                cur     <= '0;
                len_l   <= buf_len;
                bit_err <= 1'b0;
            end else if (miss) begin
                st      <= ST_IDLE;
                bit_err <= 1'b1;
            end else if (busy) begin
                if (mid && cur.pos != POS_START && !at_stop)
                    shreg[dpos[SEL_W-1:0]] <= rxd;
                if (last) begin
                    if (at_stop) begin
                        if (last_slot) begin
                            st <= ST_IDLE;
                        end else begin
                            cur.slot <= cur.slot + 1'b1;
                            cur.pos  <= POS_START;
                        end
                    end else begin
                        cur.pos <= cur.pos + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(req_q) && $past(armed)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!req_q && !busy));

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !armed);

    // R7
    abort_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bit_err) |-> (tx_line && !busy && !req_q));

    // R8
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> len_ok(len_l));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$rose(busy) && $past(!busy)) |-> $stable(bit_err));

endmodule

// File: rtl/lin_resp_tx.sv
module lin_resp_tx
    import lin_resp_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hdr_ok,
    input  logic                    req_set,
    input  logic [3:0]              buf_len,
    input  logic                    host_we,
    input  logic [3:0]              host_idx,
    input  logic [7:0]              host_data,
    input  logic                    rxd,
    output logic                    txd,
    output logic                    tx_done,
    output logic                    bit_err,
    output logic                    req_pending,
    output logic [71:0]             buf_q
);
    logic  busy, mid, last;
    idx_t  rd_idx;
    byte_t rd_data;
    wr_t   host_wr, rb_wr;

    always_comb begin
        host_wr.en   = host_we && !busy;
        host_wr.idx  = idx_t'(host_idx);
        host_wr.data = host_data;
    end

    lin_resp_bitclk #(.BIT_CLKS(BIT_CLKS)) u_bitclk (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mid  (mid),
        .last (last)
    );

    lin_resp_store u_store (
        .clk     (clk),
        .rst     (rst),
        .host_wr (host_wr),
        .rb_wr   (rb_wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .flat    (buf_q)
    );

    lin_resp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .hdr_ok  (hdr_ok),
        .req_set (req_set),
        .buf_len (buf_len),
        .rxd     (rxd),
        .mid     (mid),
        .last    (last),
        .rd_data (rd_data),
        .busy    (busy),
        .rd_idx  (rd_idx),
        .rb_wr   (rb_wr),
        .tx_line (txd),
        .done    (tx_done),
        .bit_err (bit_err),
        .req_q   (req_pending)
    );

    // R4
    host_block_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we && !rb_wr.en) |=> $stable(buf_q));

    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !tx_done) |-> txd);

endmodule

// File: tb/lin_resp_tx_test.sv
module lin_resp_tx_test;
    localparam int BC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_ok = 1'b0, req_set = 1'b0, host_we = 1'b0;
    logic [3:0]  buf_len = 4'd1, host_idx = 4'd0;
    logic [7:0]  host_data = 8'd0;
    logic        force_low = 1'b0;
    logic        txd, tx_done, bit_err, req_pending, rxd;
    logic [71:0] buf_q;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_buf [9];

    always #2 clk = ~clk;

    assign rxd = txd & ~force_low;

    lin_resp_tx #(.BIT_CLKS(BC)) uut (
        .clk(clk), .rst(rst), .hdr_ok(hdr_ok), .req_set(req_set),
        .buf_len(buf_len), .host_we(host_we), .host_idx(host_idx),
        .host_data(host_data), .rxd(rxd), .txd(txd), .tx_done(tx_done),
        .bit_err(bit_err), .req_pending(req_pending), .buf_q(buf_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] slot_of(input int i);
        return buf_q[i*8 +: 8];
    endfunction

    function automatic logic exp_level(input int sl, input int ps);
        if (ps == 0) return 1'b0;
        if (ps == 9) return 1'b1;
        return exp_buf[sl][ps-1];
    endfunction

    task automatic hwrite(input int idx, input logic [7:0] d);
        host_we = 1'b1; host_idx = 4'(idx); host_data = d;
        @(negedge clk);
        host_we = 1'b0;
        if (idx < 9) exp_buf[idx] = d;
    endtask

    task automatic pulse_hdr();
        hdr_ok = 1'b1; @(negedge clk); hdr_ok = 1'b0;
    endtask

    task automatic pulse_req();
        req_set = 1'b1; @(negedge clk); req_set = 1'b0;
    endtask

    task automatic pulse_both();
        hdr_ok = 1'b1; req_set = 1'b1; @(negedge clk);
        hdr_ok = 1'b0; req_set = 1'b0;
    endtask

    task automatic load_random();
        for (int i = 0; i < 9; i++) hwrite(i, 8'($urandom));
    endtask

    task automatic quiet_window(input int n, input string req, input string what);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            if (txd !== 1'b1 || tx_done !== 1'b0) lows++;
            @(negedge clk);
        end
        check(lows == 0, req, what, lows, 0);
    endtask

    task automatic check_buffer(input string what);
        for (int i = 0; i < 9; i++)
            check(slot_of(i) == exp_buf[i], "R4", what, slot_of(i), exp_buf[i]);
    endtask

    // Watch one response from its start bit; optional host write while busy,
    // optional forced-low bit at (inj_slot, inj_pos)
    task automatic observe(input int len, input int wr_slot,
                           input int inj_slot, input int inj_pos);
        int waitc = 0;
        int total;
        int bad = 0;
        int early = 0;
        while (txd !== 1'b0 && waitc < 64) begin
            @(negedge clk); waitc++;
        end
        check(txd == 1'b0, "R2", "response start bit", txd, 0);
        if (txd !== 1'b0) return;
        check(bit_err == 1'b0, "R9", "bit_err cleared at start", bit_err, 0);
        total = len * 10 * BC;
        for (int i = 0; i < total; i++) begin
            int sl, ps, ph;
            sl = i / (10 * BC);
            ps = (i / BC) % 10;
            ph = i % BC;
            if (inj_slot >= 0 && sl == inj_slot && ps == inj_pos && ph == 0)
                force_low = 1'b1;
            if (wr_slot >= 0 && i == BC) begin
                host_we = 1'b1; host_idx = 4'(wr_slot); host_data = ~exp_buf[wr_slot];
            end
            if (wr_slot >= 0 && i == BC + 1) host_we = 1'b0;
            if (ph == BC / 2 && txd !== exp_level(sl, ps)) bad++;
            if (tx_done) early++;
            if (inj_slot >= 0 && sl == inj_slot && ps == inj_pos && ph == BC / 2 + 1) begin
                check(bit_err == 1'b1, "R7", "bit_err after mismatch", bit_err, 1);
                check(txd == 1'b1, "R7", "line high after abort", txd, 1);
                check(req_pending == 1'b0, "R7", "request cleared on abort", req_pending, 0);
                force_low = 1'b0;
                check(bad == 0 && early == 0, "R7", "bytes before abort", bad + early, 0);
                quiet_window(20 * BC, "R7", "no output and no done after abort");
                check_buffer("aborted slot not rewritten");
                return;
            end
            if (ps == 9 && ph == BC - 1) begin
                check(bad == 0, "R3", $sformatf("byte on line slot %0d", sl), bad, 0);
                bad = 0;
            end
            @(negedge clk);
        end
        check(tx_done == 1'b1 && early == 0, "R5", "done at end of last stop bit",
              {early[7:0], 3'b0, tx_done}, 1);
        check(req_pending == 1'b0, "R5", "request cleared on completion", req_pending, 0);
        @(negedge clk);
        check(tx_done == 1'b0, "R5", "done one cycle wide", tx_done, 0);
        check(txd == 1'b1, "R10", "line idle high after response", txd, 1);
        check_buffer("readback after response");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        for (int i = 0; i < 9; i++) exp_buf[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(tx_done == 1'b0, "R1", "done after reset", tx_done, 0);
        check(bit_err == 1'b0, "R1", "bit_err after reset", bit_err, 0);
        check(req_pending == 1'b0, "R1", "request after reset", req_pending, 0);
        check(buf_q == 72'd0, "R1", "buffer after reset", int'(buf_q[31:0]), 0);

        // R2 request without header does nothing
        load_random();
        buf_len = 4'd3;
        pulse_req();
        quiet_window(40, "R2", "no start without header");
        check(req_pending == 1'b1, "R2", "request held waiting", req_pending, 1);
        pulse_hdr();
        observe(3, -1, -1, 0);

        // R6 second request needs a new header
        pulse_req();
        quiet_window(40, "R6", "no start before new header");
        pulse_hdr();
        observe(3, -1, -1, 0);

        // R3 full length, header and request in the same cycle
        load_random();
        buf_len = 4'd9;
        pulse_both();
        observe(9, -1, -1, 0);

        // R4 host write on the start edge lands and is sent
        load_random();
        buf_len = 4'd2;
        pulse_hdr();
        pulse_req();
        hwrite(0, 8'hA5);
        observe(2, -1, -1, 0);

        // R4 host write while busy ignored
        load_random();
        buf_len = 4'd9;
        pulse_both();
        observe(9, 5, -1, 0);

        // R8 invalid lengths, header stays armed
        pulse_hdr();
        buf_len = 4'd0;
        pulse_req();
        @(negedge clk);
        check(req_pending == 1'b0, "R8", "request cleared for length 0", req_pending, 1'b0);
        quiet_window(30, "R8", "no output for length 0");
        buf_len = 4'd10;
        pulse_req();
        @(negedge clk);
        check(req_pending == 1'b0, "R8", "request cleared for length 10", req_pending, 0);
        buf_len = 4'd15;
        pulse_req();
        quiet_window(30, "R8", "no output for length 15");
        check(req_pending == 1'b0, "R8", "request cleared for length 15", req_pending, 0);
        buf_len = 4'd1;
        pulse_req();
        observe(1, -1, -1, 0);

        // R7 mismatch on a data bit
        load_random();
        hwrite(2, 8'hFF);
        buf_len = 4'd5;
        pulse_both();
        observe(5, -1, 2, 4);
        quiet_window(40, "R9", "bit_err idle period");
        check(bit_err == 1'b1, "R9", "bit_err held while idle", bit_err, 1);

        // R7 mismatch on a stop bit, then R9 clear on next start
        load_random();
        buf_len = 4'd4;
        pulse_both();
        observe(4, -1, 0, 9);
        pulse_both();
        observe(4, -1, -1, 0);

        // random responses
        for (int k = 0; k < 6; k++) begin
            int len;
            len = 1 + int'($urandom % 9);
            load_random();
            buf_len = 4'(len);
            if (k % 2 == 0) pulse_both();
            else begin pulse_req(); pulse_hdr(); end
            observe(len, -1, -1, 0);
            repeat (int'($urandom % 5)) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule